// File: doc/BRIEF.md
# Serial Converter Link Endpoint Model

This block is the converter end of a three-wire serial link, written as synthesizable logic so a host-side receiver can be tested in a closed loop without the analog part. It runs on a fast system clock and watches two link inputs, the serial clock and the conversion-start line. Both are sampled, and their rising edges are found inside the block. The converted value is not produced here: it arrives as a parallel word and is captured when a conversion is requested.

A conversion frame puts a reference-ready status bit on the data line, then the captured word from the most significant bit down. Each bit is launched by a rising edge of the serial clock. The data line is given as a value plus a drive enable, so a pad or a loopback model can form the high-impedance state. Pulses on the start line while the serial clock is held low select two low-power states. The next serial clock edge brings the block back. After the deeper state, the reference-ready flag stays clear for a programmable number of serial clock edges.

No handshake is used on the sample input or the serial output: the sample word is taken, without back-pressure, in the cycle the start edge is seen, and the receiver must take each bit on the serial clock with no means to stall.

Top module: `sadc_link_model`

## Requirements
- R1: After reset the power state is active (code 2'b00), the drive enable is low, the data value is 0 and reference-ready is 1.
- R2: A start rising edge while the block is active and idle captures `sample_i`. The first serial clock rising edge that starts the frame drives the reference-ready value. The next 12 rising edges drive sample bits 11 down to 0, one bit per edge. Each result is visible one system clock after the edge is sampled.
- R3: The drive enable is low before the frame starts. It is high from the frame's first edge through the last data bit. It goes low on the 13th rising edge after the frame's first edge.
- R4: A start edge that arrives while a frame is pending or being shifted out has no effect on the frame's data.
- R5: A frame starts on a serial clock rising edge only if at least SETUP_CYC system clocks separate the sampled start edge from that edge. If they are closer, the frame starts on the following rising edge.
- R6: The block counts start rising edges seen while the serial clock is low, and the count clears on every serial clock rise. If a rise finds the block active with a count of exactly 2, it enters nap (code 2'b01). A count of exactly 4 enters sleep (code 2'b10), and in both cases no frame starts.
- R7: Any other count at that rise, such as 3, leaves the power state active, and a pending frame starts as usual.
- R8: Any serial clock rising edge in nap or sleep returns the state to active.
- R9: Entering sleep clears reference-ready. After the waking edge it stays clear until SETTLE_EDGES further serial clock rising edges have occurred, and a frame started in that window carries 0 as its status bit. Nap leaves reference-ready set.
- R10: The data value is 0 whenever the drive enable is low. The drive enable is never high outside the active state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the link |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the receiver |
| conv_i | input | 1 | Conversion-start line |
| sample_i | input | DATA_W | Word standing in for the converted value |
| sdata_o | output | 1 | Serial data value |
| sdata_oe_o | output | 1 | Drive enable of the serial data line (low means high-impedance) |
| pwr_state_o | output | 2 | Power state: 00 active, 01 nap, 10 sleep |
| ref_ready_o | output | 1 | Reference settled flag |

## Verification
Every output of this block moves one system clock after a serial clock or start edge is sampled: data bits, the enable, the power state and the settle count all update there. The bench drives each serial clock level on a falling system clock edge, waits two system clocks, and only then samples, so every check sees the value due for that edge. The setup case puts the serial clock rise one system clock after the start edge. The normal cases leave far more than SETUP_CYC clocks. The settle window is checked by counting serial clock rises after wake and expecting reference-ready to turn on exactly at the SETTLE_EDGES-th one.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  typedef enum logic [1:0] {
    PWR_ACTIVE = 2'b00,
    PWR_NAP    = 2'b01,
    PWR_SLEEP  = 2'b10
  } pwr_e;
endpackage

// File: rtl/sadc_edge_det.sv
// Samples a group of link inputs and flags their rising edges.
module sadc_edge_det #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] rise
);
  logic [WIDTH-1:0] prev_q;

  // Resetting the history high keeps a line that is already high from
  // producing a false edge when reset releases.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= din;
  end

  for (genvar g = 0; g < WIDTH; g++) begin : g_rise
    assign rise[g] = din[g] & ~prev_q[g];
  end
endmodule

// File: rtl/sadc_pwr_ctrl.sv
// Pulse counting, power state and reference settle model.
module sadc_pwr_ctrl
  import sadc_pkg::*;
#(
  parameter int SETTLE_EDGES = 8,
  parameter int PULSE_W      = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_rise,
  input  logic sclk_lvl,
  input  logic conv_rise,
  input  logic frame_busy,
  output pwr_e state,
  output logic ref_ready,
  output logic enter_low
);
  localparam int SET_W = $clog2(SETTLE_EDGES + 1);
  localparam logic [PULSE_W-1:0] PULSE_MAX = '1;
  localparam logic [PULSE_W-1:0] NAP_CNT   = PULSE_W'(2);
  localparam logic [PULSE_W-1:0] SLEEP_CNT = PULSE_W'(4);
  localparam logic [SET_W-1:0]   SETTLE_LD = SET_W'(SETTLE_EDGES);

  logic [PULSE_W-1:0] pulses;
  logic [SET_W-1:0]   settle;
  logic               is_active;
  logic               go_nap;
  logic               go_sleep;

  always_comb begin
    is_active = (state == PWR_ACTIVE);
    go_nap    = sclk_rise & is_active & (pulses == NAP_CNT);
    go_sleep  = sclk_rise & is_active & (pulses == SLEEP_CNT);
    enter_low = go_nap | go_sleep;
    ref_ready = (settle == '0);
  end

  // Start edges seen with the serial clock low; any serial clock rise clears.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulses <= '0;
    end else if (sclk_rise) begin
      pulses <= '0;
    end else if (conv_rise && !sclk_lvl && !frame_busy && pulses != PULSE_MAX) begin
      pulses <= pulses + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PWR_ACTIVE;
    end else if (sclk_rise) begin
      if (!is_active)    state <= PWR_ACTIVE;
      else if (go_nap)   state <= PWR_NAP;
      else if (go_sleep) state <= PWR_SLEEP;
    end
  end

  // Loaded on sleep entry; counts down only on active-state serial edges,
  // so the waking edge itself does not count.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle <= '0;
    end else if (go_sleep) begin
      settle <= SETTLE_LD;
    end else if (sclk_rise && is_active && settle != '0) begin
      settle <= settle - 1'b1;
    end
  end
endmodule

// File: rtl/sadc_frame_tx.sv
// Frame sequencer: capture, setup window, status bit and data shift-out.
module sadc_frame_tx #(
  parameter int DATA_W    = 12,
  parameter int SETUP_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise,
  input  logic              conv_rise,
  input  logic              accept,
  input  logic              cancel,
  input  logic              ref_ready,
  input  logic [DATA_W-1:0] sample,
  output logic              busy,
  output logic              sd
);
  localparam int IDX_W = $clog2(DATA_W + 1);
  localparam int AGE_W = $clog2(SETUP_CYC + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W);
  localparam logic [AGE_W-1:0] AGE_OK   = AGE_W'(SETUP_CYC);

  logic              pending;
  logic [AGE_W-1:0]  age;
  logic [DATA_W-1:0] hold;
  logic [IDX_W-1:0]  idx;
  logic              arm;
  logic              launch;
  logic              drop;

  always_comb begin
    arm    = conv_rise & accept & ~busy & ~pending;
    launch = sclk_rise & pending & ~cancel & (age >= AGE_OK);
    drop   = sclk_rise & pending & cancel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      age     <= '0;
    end else if (arm) begin
      pending <= 1'b1;
      age     <= AGE_W'(1);
    end else begin
      if (launch || drop) pending <= 1'b0;
      if (pending && age < AGE_OK) age <= age + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= '0;
    end else if (arm) begin
      hold <= sample;
    end else if (sclk_rise && busy && idx != LAST_IDX) begin
      hold <= hold << 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sd   <= 1'b0;
      idx  <= '0;
    end else if (launch) begin
      busy <= 1'b1;
      sd   <= ref_ready;
      idx  <= '0;
    end else if (sclk_rise && busy) begin
      if (idx == LAST_IDX) begin
        busy <= 1'b0;
        sd   <= 1'b0;
      end else begin
        sd  <= hold[DATA_W-1];
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sadc_link_model.sv
module sadc_link_model
  import sadc_pkg::*;
#(
  parameter int DATA_W       = 12,
  parameter int SETUP_CYC    = 3,
  parameter int SETTLE_EDGES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              conv_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              sdata_o,
  output logic              sdata_oe_o,
  output logic [1:0]        pwr_state_o,
  output logic              ref_ready_o
);
  localparam int LINK_W = 2;

  logic [LINK_W-1:0] link_rise;
  logic              sclk_rise;
  logic              conv_rise;
  pwr_e              state;
  logic              ref_ready;
  logic              enter_low;
  logic              busy;
  logic              sd;

  sadc_edge_det #(.WIDTH(LINK_W)) u_edges (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({conv_i, sclk_i}),
    .rise (link_rise)
  );

  assign sclk_rise = link_rise[0];
  assign conv_rise = link_rise[1];

  sadc_pwr_ctrl #(.SETTLE_EDGES(SETTLE_EDGES)) u_pwr (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_rise (sclk_rise),
    .sclk_lvl  (sclk_i),
    .conv_rise (conv_rise),
    .frame_busy(busy),
    .state     (state),
    .ref_ready (ref_ready),
    .enter_low (enter_low)
  );

  sadc_frame_tx #(.DATA_W(DATA_W), .SETUP_CYC(SETUP_CYC)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_rise(sclk_rise),
    .conv_rise(conv_rise),
    .accept   (state == PWR_ACTIVE),
    .cancel   (enter_low),
    .ref_ready(ref_ready),
    .sample   (sample_i),
    .busy     (busy),
    .sd       (sd)
  );

  assign sdata_o     = sd;
  assign sdata_oe_o  = busy;
  assign pwr_state_o = state;
  assign ref_ready_o = ref_ready;
endmodule

// File: rtl/sadc_link_checks.sv
module sadc_link_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       sclk_i,
  input logic       sdata_o,
  input logic       sdata_oe_o,
  input logic [1:0] pwr_state_o,
  input logic       ref_ready_o
);
  logic sclk_d;
  logic edge_now;
  logic edge_d;

  assign edge_now = sclk_i & ~sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b1;
      edge_d <= 1'b0;
    end else begin
      sclk_d <= sclk_i;
      edge_d <= edge_now;
    end
  end

  AST_QUIET_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    !sdata_oe_o |-> !sdata_o);  // R10

  AST_DRIVE_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    sdata_oe_o |-> (pwr_state_o == 2'b00));  // R10

  AST_SLEEP_REF_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state_o == 2'b10) |-> !ref_ready_o);  // R9

  AST_WAKE_ANY_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_now && pwr_state_o != 2'b00) |=> (pwr_state_o == 2'b00));  // R8

  AST_BIT_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_d |-> $stable(sdata_o));  // R2

  AST_STATE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_d |-> $stable(pwr_state_o));  // R6
endmodule

bind sadc_link_model sadc_link_checks u_link_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .sclk_i     (sclk_i),
  .sdata_o    (sdata_o),
  .sdata_oe_o (sdata_oe_o),
  .pwr_state_o(pwr_state_o),
  .ref_ready_o(ref_ready_o)
);

// File: tb/sadc_link_model_test.sv
module sadc_link_model_test;
  localparam int CLK_PERIOD   = 10;
  localparam int DATA_W       = 12;
  localparam int SETUP_CYC    = 3;
  localparam int SETTLE_EDGES = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              sclk_i = 1'b0;
  logic              conv_i = 1'b0;
  logic [DATA_W-1:0] sample_i = '0;
  logic              sdata_o;
  logic              sdata_oe_o;
  logic [1:0]        pwr_state_o;
  logic              ref_ready_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sadc_link_model #(
    .DATA_W(DATA_W), .SETUP_CYC(SETUP_CYC), .SETTLE_EDGES(SETTLE_EDGES)
  ) uut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .conv_i(conv_i),
    .sample_i(sample_i), .sdata_o(sdata_o), .sdata_oe_o(sdata_oe_o),
    .pwr_state_o(pwr_state_o), .ref_ready_o(ref_ready_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // All link drives happen on falling system edges; results sampled two clocks later.
  task automatic edge_hi();
    sclk_i = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic edge_lo();
    sclk_i = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic conv_pulse(input logic [DATA_W-1:0] s);
    sample_i = s;
    conv_i = 1'b1;
    repeat (2) @(negedge clk);
    conv_i = 1'b0;
    repeat (SETUP_CYC + 4) @(negedge clk);
  endtask

  // Reads a frame whose first edge is the next serial rise, then the release edge.
  task automatic read_frame(input logic exp_ref, input logic [DATA_W-1:0] exp_data,
                            input string tag);
    for (int i = 0; i <= DATA_W; i++) begin
      logic exp_bit;
      exp_bit = (i == 0) ? exp_ref : exp_data[DATA_W-i];
      edge_hi();
      chk({tag, " R3 enable in frame"}, sdata_oe_o, 1'b1);
      chk({tag, " R2 frame bit"}, sdata_o, exp_bit);
      edge_lo();
    end
    edge_hi();
    chk({tag, " R3 release enable"}, sdata_oe_o, 1'b0);
    chk({tag, " R10 quiet value"}, sdata_o, 1'b0);
    edge_lo();
  endtask

  task automatic t_reset();
    chk("R1 power state", pwr_state_o, 2'b00);
    chk("R1 enable", sdata_oe_o, 1'b0);
    chk("R1 data", sdata_o, 1'b0);
    chk("R1 ref ready", ref_ready_o, 1'b1);
  endtask

  task automatic t_frame(input logic [DATA_W-1:0] s);
    conv_pulse(s);
    chk("R3 enable before start", sdata_oe_o, 1'b0);
    read_frame(1'b1, s, "frame");
  endtask

  task automatic t_ignore();
    edge_hi();                       // idle rise, clock stays high
    conv_pulse(12'h6B2);             // pending frame, not counted
    conv_pulse(12'h111);             // R4 ignored while pending
    edge_lo();
    for (int i = 0; i <= DATA_W; i++) begin
      logic [12:0] word;
      word = {1'b1, 12'h6B2};
      edge_hi();
      chk("R4 data kept", sdata_o, word[DATA_W-i]);
      edge_lo();
      if (i == 3) conv_pulse(12'hF0F);  // R4 ignored mid-frame
    end
    edge_hi();
    chk("R4 release after ignored edges", sdata_oe_o, 1'b0);
    edge_lo();
  endtask

  task automatic t_late();
    sample_i = 12'h9C3;
    conv_i = 1'b1;
    @(negedge clk);
    sclk_i = 1'b1;                   // one clock after the start edge
    repeat (2) @(negedge clk);
    chk("R5 no start on close edge", sdata_oe_o, 1'b0);
    conv_i = 1'b0;
    edge_lo();
    read_frame(1'b1, 12'h9C3, "late");
  endtask

  task automatic t_nap();
    conv_pulse(12'h0AA);
    conv_pulse(12'h0AA);
    edge_hi();
    chk("R6 nap entered", pwr_state_o, 2'b01);
    chk("R6 no frame on nap", sdata_oe_o, 1'b0);
    chk("R9 nap keeps ref", ref_ready_o, 1'b1);
    edge_lo();
    edge_hi();
    chk("R8 wake from nap", pwr_state_o, 2'b00);
    edge_lo();
  endtask

  task automatic enter_sleep();
    for (int i = 0; i < 4; i++) conv_pulse(12'h555);
    edge_hi();
    chk("R6 sleep entered", pwr_state_o, 2'b10);
    chk("R9 sleep clears ref", ref_ready_o, 1'b0);
    edge_lo();
    edge_hi();
    chk("R8 wake from sleep", pwr_state_o, 2'b00);
    chk("R9 ref clear after wake", ref_ready_o, 1'b0);
    edge_lo();
  endtask

  task automatic t_sleep();
    enter_sleep();
    conv_pulse(12'hC35);
    read_frame(1'b0, 12'hC35, "settling");
    chk("R9 ref set after window", ref_ready_o, 1'b1);
    enter_sleep();
    for (int r = 1; r <= SETTLE_EDGES; r++) begin
      edge_hi();
      chk("R9 settle count", ref_ready_o, (r >= SETTLE_EDGES) ? 1'b1 : 1'b0);
      edge_lo();
    end
  endtask

  task automatic t_three();
    for (int i = 0; i < 3; i++) conv_pulse(12'h7E4);
    chk("R7 enable before edge", sdata_oe_o, 1'b0);
    read_frame(1'b1, 12'h7E4, "R7 three pulses");
    chk("R7 state unchanged", pwr_state_o, 2'b00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_frame(12'hA5C);
    t_frame(12'h3F1);
    t_frame(12'h000);
    t_frame(12'hFFF);
    t_ignore();
    t_late();
    t_nap();
    t_sleep();
    t_three();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule